// File: doc/BRIEF.md
# Message Buffer Interrupt Flags with Receive FIFO Status

This block holds one sticky interrupt flag per message buffer for buffers 0 to 31. A flag goes high when its buffer reports a finished transmission or reception through a one-cycle done strobe. Software clears flags by writing ones, and a single interrupt line is raised whenever an enabled flag is high. The enable vector comes from outside the block.

A mode input switches the low flags to receive FIFO status. In that mode the block follows the occupancy of a six-entry receive FIFO, using push and pop strobes from the FIFO logic. Flag 5 then means frames are waiting, flag 6 warns that five of the six entries are full, and flag 7 reports a frame lost because the FIFO was full. Flags 0 to 4 are reserved in that mode and read as zero. Buffers 8 and up behave the same in both modes.

Top module: `bufFlagUnit`

## Requirements
- R1: In either mode, a high `mbDone[i]` for i in 8..31 sets `flagsOut[i]` on the next clock edge.
- R2: With `fifoMode` low, a high `mbDone[i]` for i in 0..7 sets `flagsOut[i]` on the next clock edge.
- R3: With `fifoMode` high, `flagsOut[5]` sets on any cycle where an accepted push or pop leaves the occupancy nonzero. This includes re-setting after software clears it.
- R4: With `fifoMode` high, `flagsOut[6]` sets when an accepted push with no pop moves the occupancy from 4 to 5. Reaching 5 by popping down from 6 does not set it.
- R5: With `fifoMode` high, a push at occupancy 6 with no pop in the same cycle is dropped. It sets `flagsOut[7]`, does not change the occupancy, and does not set `flagsOut[5]`.
- R6: With `fifoMode` high, `flagsOut[4:0]` read as zero and `mbDone[4:0]` has no effect on them.
- R7: When `wrEn` is high, each bit of `wrData` that is 1 clears the matching flag on the next edge, and bits that are 0 leave their flags unchanged. A set event on the same cycle as a clear wins, and the flag stays high.
- R8: `irqOut` is the OR of `flagsOut & maskIn`, with no added clock delay.
- R9: After reset, all flags are zero and the occupancy is zero.
- R10: With `fifoMode` low, push and pop are ignored and the occupancy stays zero. A pop at occupancy 0 is ignored. A push together with a pop at occupancy 6 is accepted and is not an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoMode | input | 1 | High selects the receive FIFO meaning of flags 0 to 7 |
| mbDone | input | 32 | One-cycle completion strobe for each buffer |
| fifoPush | input | 1 | A frame is offered to the receive FIFO |
| fifoPop | input | 1 | The reader removes a frame from the receive FIFO |
| wrEn | input | 1 | CPU write strobe for flag clearing |
| wrData | input | 32 | Write-one-to-clear data |
| maskIn | input | 32 | Interrupt enable per flag |
| flagsOut | output | 32 | Current flag register |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 32 flags, a six-entry FIFO, a warning level of five, and status bits at 5, 6 and 7. These values match the layout in the requirements. A depth of six lets a short push and pop run fill the FIFO and force a dropped frame. Draining it pop by pop then shows, through the frames-waiting flag, that the dropped frame was never counted. The same run reaches the 4-to-5 warning edge, the full-with-pop case and the empty-pop case.

// File: rtl/bfPkg.sv
package bfPkg;
  // Status strobes from the occupancy tracker to the flag register.
  typedef struct packed {
    logic availEvt;
    logic warnEvt;
    logic ovfEvt;
  } fifoEvt_t;
endpackage

// File: rtl/fifoTracker.sv
module fifoTracker
  import bfPkg::*;
#(
  parameter int FIFO_DEPTH = 6,
  parameter int WARN_LEVEL = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     fifoMode,
  input  logic     pushReq,
  input  logic     popReq,
  output fifoEvt_t evt
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] PRE_WARN_C = CNT_W'(WARN_LEVEL - 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] nextCount;
  logic popTaken;
  logic pushTaken;

  always_comb begin
    popTaken  = fifoMode && popReq && (count != '0);
    // A pop on the same cycle frees a slot, so a full FIFO still takes the push.
    pushTaken = fifoMode && pushReq && ((count < DEPTH_C) || popTaken);
    nextCount = count;
    if (!fifoMode) begin
      nextCount = '0;
    end else if (pushTaken && !popTaken) begin
      nextCount = count + 1'b1;
    end else if (popTaken && !pushTaken) begin
      nextCount = count - 1'b1;
    end
    evt.ovfEvt   = fifoMode && pushReq && !pushTaken;
    evt.warnEvt  = pushTaken && !popTaken && (count == PRE_WARN_C);
    evt.availEvt = (pushTaken || popTaken) && (nextCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= nextCount;
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  p_drop_keeps_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovfEvt |=> $stable(count));

  p_idle_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |=> (count == '0));

  p_warn_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    evt.warnEvt |=> (count == CNT_W'(WARN_LEVEL)));
endmodule

// File: rtl/flagDatapath.sv
module flagDatapath
  import bfPkg::*;
#(
  parameter int NUM_FLAGS = 32,
  parameter int RSVD_BITS = 5,
  parameter int AVAIL_BIT = 5,
  parameter int WARN_BIT  = 6,
  parameter int OVF_BIT   = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fifoMode,
  input  logic [NUM_FLAGS-1:0] mbDone,
  input  fifoEvt_t             evt,
  input  logic                 wrEn,
  input  logic [NUM_FLAGS-1:0] wrData,
  output logic [NUM_FLAGS-1:0] flags
);
  localparam int UPPER_LO = OVF_BIT + 1;

  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] clrVec;
  logic [NUM_FLAGS-1:0] keepVec;
  logic [NUM_FLAGS-1:0] nextFlags;

  always_comb begin
    setVec  = mbDone;
    keepVec = '1;
    if (fifoMode) begin
      setVec[RSVD_BITS-1:0]  = '0;
      keepVec[RSVD_BITS-1:0] = '0;
      setVec[AVAIL_BIT]      = evt.availEvt;
      setVec[WARN_BIT]       = evt.warnEvt;
      setVec[OVF_BIT]        = evt.ovfEvt;
    end
    clrVec    = wrEn ? wrData : '0;
    nextFlags = ((flags & ~clrVec) | setVec) & keepVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= nextFlags;
  end

  p_upper_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|mbDone[NUM_FLAGS-1:UPPER_LO]) |=>
      ((flags[NUM_FLAGS-1:UPPER_LO] & $past(mbDone[NUM_FLAGS-1:UPPER_LO]))
        == $past(mbDone[NUM_FLAGS-1:UPPER_LO])));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    fifoMode |=> (flags[RSVD_BITS-1:0] == '0));

  p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovfEvt |=> flags[OVF_BIT]);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((flags & $past(wrData) & ~$past(setVec)) == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && (setVec == '0) && (!fifoMode || (flags[RSVD_BITS-1:0] == '0)))
      |=> $stable(flags));
endmodule

// File: rtl/bufFlagUnit.sv
module bufFlagUnit
  import bfPkg::*;
#(
  parameter int NUM_FLAGS  = 32,
  parameter int FIFO_DEPTH = 6,
  parameter int WARN_LEVEL = 5,
  parameter int RSVD_BITS  = 5,
  parameter int AVAIL_BIT  = 5,
  parameter int WARN_BIT   = 6,
  parameter int OVF_BIT    = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fifoMode,
  input  logic [NUM_FLAGS-1:0] mbDone,
  input  logic                 fifoPush,
  input  logic                 fifoPop,
  input  logic                 wrEn,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic [NUM_FLAGS-1:0] maskIn,
  output logic [NUM_FLAGS-1:0] flagsOut,
  output logic                 irqOut
);
  fifoEvt_t fifoEvt;

  fifoTracker #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .WARN_LEVEL(WARN_LEVEL)
  ) u_tracker (
    .clk     (clk),
    .rstN    (rstN),
    .fifoMode(fifoMode),
    .pushReq (fifoPush),
    .popReq  (fifoPop),
    .evt     (fifoEvt)
  );

  flagDatapath #(
    .NUM_FLAGS(NUM_FLAGS),
    .RSVD_BITS(RSVD_BITS),
    .AVAIL_BIT(AVAIL_BIT),
    .WARN_BIT (WARN_BIT),
    .OVF_BIT  (OVF_BIT)
  ) u_flags (
    .clk     (clk),
    .rstN    (rstN),
    .fifoMode(fifoMode),
    .mbDone  (mbDone),
    .evt     (fifoEvt),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .flags   (flagsOut)
  );

  assign irqOut = |(flagsOut & maskIn);
endmodule

// File: tb/bufFlagUnit_bench.sv
module bufFlagUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoMode = 1'b0;
  logic [31:0] mbDone = '0;
  logic        fifoPush = 1'b0;
  logic        fifoPop = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] maskIn = '0;
  logic [31:0] flagsOut;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;

  bufFlagUnit u_bufFlagUnit (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .mbDone(mbDone),
    .fifoPush(fifoPush), .fifoPop(fifoPop), .wrEn(wrEn), .wrData(wrData),
    .maskIn(maskIn), .flagsOut(flagsOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, release it at the next falling edge.
  task automatic step(input logic push, input logic pop, input logic [31:0] done,
                      input logic wr, input logic [31:0] data);
    @(negedge clk);
    fifoPush = push; fifoPop = pop; mbDone = done; wrEn = wr; wrData = data;
    @(negedge clk);
    fifoPush = 1'b0; fifoPop = 1'b0; mbDone = '0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic clearAll();
    step(1'b0, 1'b0, '0, 1'b1, 32'hFFFF_FFFF);
  endtask

  task automatic testReset();
    check("R9 flags after reset", flagsOut, 32'h0);
    maskIn = 32'hFFFF_FFFF;
    #1;
    check("R9 irq after reset", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testBufferMode();
    fifoMode = 1'b0;
    step(1'b0, 1'b0, 32'h8000_0081, 1'b0, '0);
    check("R2 R1 buffer flags set", flagsOut, 32'h8000_0081);
    step(1'b0, 1'b0, '0, 1'b1, 32'h0000_0080);
    check("R7 write one clears", flagsOut, 32'h8000_0001);
    step(1'b0, 1'b0, '0, 1'b1, 32'h0000_0000);
    check("R7 write zero no effect", flagsOut, 32'h8000_0001);
    step(1'b0, 1'b0, 32'h0000_0001, 1'b1, 32'h0000_0001);
    check("R7 set wins over clear", flagsOut, 32'h8000_0001);
  endtask

  task automatic testIrq();
    maskIn = 32'h0000_0001; #1;
    check("R8 irq enabled flag", {31'b0, irqOut}, 32'h1);
    maskIn = 32'h0000_0002; #1;
    check("R8 irq masked", {31'b0, irqOut}, 32'h0);
    maskIn = 32'h8000_0000; #1;
    check("R8 irq top flag", {31'b0, irqOut}, 32'h1);
    maskIn = '0;
    clearAll();
    check("R7 clear all", flagsOut, 32'h0);
  endtask

  task automatic testModeOffIgnores();
    fifoMode = 1'b0;
    step(1'b1, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R10 push ignored in buffer mode", flagsOut, 32'h0);
    fifoMode = 1'b1;
    step(1'b0, 1'b1, '0, 1'b0, '0);
    check("R10 pop at empty ignored", flagsOut, 32'h0);
  endtask

  task automatic testReserved();
    fifoMode = 1'b0;
    step(1'b0, 1'b0, 32'h0000_0004, 1'b0, '0);
    fifoMode = 1'b1;
    step(1'b0, 1'b0, 32'h0010_001F, 1'b0, '0);
    check("R6 reserved zero, R1 upper set in fifo mode", flagsOut, 32'h0010_0000);
    clearAll();
  endtask

  task automatic testFifoFill();
    fifoMode = 1'b1;
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R3 avail after first push", flagsOut, 32'h20);
    step(1'b0, 1'b0, '0, 1'b1, 32'h20);
    check("R7 avail cleared", flagsOut, 32'h0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R3 avail at four", flagsOut, 32'h20);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R4 warn at five", flagsOut, 32'h60);
    clearAll();
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R4 no warn at six", flagsOut, 32'h20);
    clearAll();
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R5 overflow only", flagsOut, 32'h80);
    clearAll();
    step(1'b1, 1'b1, '0, 1'b0, '0);
    check("R10 push with pop when full", flagsOut, 32'h20);
  endtask

  task automatic testDrain();
    for (int i = 0; i < 5; i++) begin
      clearAll();
      step(1'b0, 1'b1, '0, 1'b0, '0);
    end
    check("R3 avail after fifth pop, R4 no warn on way down", flagsOut, 32'h20);
    clearAll();
    step(1'b0, 1'b1, '0, 1'b0, '0);
    check("R5 dropped frame not counted", flagsOut, 32'h0);
    step(1'b0, 1'b1, '0, 1'b0, '0);
    check("R10 pop at empty", flagsOut, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBufferMode();
    testIrq();
    testModeOffIgnores();
    testReserved();
    testFifoFill();
    testDrain();
    doneFlag = 1'b1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule